// File: doc/BRIEF.md
# Dual Half-Bridge Gate Sequencer

This block turns the logic-level commands for two independent half-bridge legs into four gate-enable signals. It is safe for the power stage. Each leg has a low-side command and a high-side command. The block synchronises these commands and filters out narrow glitches. It then resolves conflicts in favour of the low-side switch. Every turn-on is delayed by a programmable number of clock cycles. Every turn-off takes effect without that delay. As a result, the two switches of one leg can never conduct together.

A shared disable input and a shared supply-undervoltage flag force all four gates off. Each leg also has a bootstrap-undervoltage flag that blocks only its high-side gate. When the block leaves the disabled or undervoltage state, both low-side gates give a fixed-length pulse that recharges the bootstrap capacitors. The high-side gates stay off until after that pulse. If a leg's high-side command is tied high, its low-side command alone drives the leg as a complementary pair.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While the disable input is 1, all four gate outputs are 0. A rise of the disable input forces every output to 0 by the 3rd rising clock edge after the change, whatever the leg commands do.
- R2: While the supply-undervoltage flag is 1, all four gate outputs are 0. The outputs are forced to 0 by the 3rd rising edge after the flag rises.
- R3: In a leg whose low-side and high-side commands are both 1, the low-side gate is on and the high-side gate is off.
- R4: In a leg whose low-side command is 0 and high-side command is 1, the high-side gate turns on only while that leg's bootstrap-undervoltage flag is 0. When the flag is 1, the high-side gate goes off by the 3rd edge and stays off.
- R5: In a leg whose two commands are both 0, both gates are off.
- R6: A gate turns off on rising edge MIN_PULSE+3 after its command changes (two synchroniser stages, MIN_PULSE filter cycles, one output register). A gate turns on exactly deadCycles edges later than that, so with deadCycles = 0 on and off latencies are equal.
- R7: In a leg whose high-side command is held at 1, toggling the low-side command alternates the two gates. Each gate turns on exactly deadCycles edges after the other gate turns off.
- R8: The two legs are independent. Activity on one leg's commands or on its bootstrap flag never changes the other leg's gates.
- R9: When disable and supply undervoltage are both released, both low-side gates rise on the 3rd edge and stay on for exactly REFRESH_LEN cycles. A high-side gate then turns on no earlier than deadCycles+1 edges after the refresh pulse ends.
- R10: A command pulse narrower than MIN_PULSE cycles has no effect on the gates. A pulse W >= MIN_PULSE cycles wide produces a gate pulse W - deadCycles cycles wide when W > deadCycles.
- R11: During reset, and after it until commanded otherwise, all gates are 0. Reset treats disable and both undervoltage flags as active.
- R12: A turn-on request that is withdrawn before its dead-time count ends produces no gate pulse. A new request starts a fresh count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| disableIn | input | 1 | 1 forces all gates off |
| supplyUv | input | 1 | Qualified supply-undervoltage flag, 1 = undervoltage |
| bootUv | input | NUM_LEGS | Per-leg bootstrap-undervoltage flag, bit 0 = leg A |
| lowIn | input | NUM_LEGS | Per-leg low-side command, bit 0 = leg A |
| highIn | input | NUM_LEGS | Per-leg high-side command, bit 0 = leg A |
| deadCycles | input | DEAD_W | Turn-on delay in clock cycles |
| lowGate | output | NUM_LEGS | Per-leg low-side gate enable |
| highGate | output | NUM_LEGS | Per-leg high-side gate enable |

## Verification
The bench measures the exact edge on which each output changes. A design that delayed turn-off, or that skipped the dead time on one side, would show wrong latency differences and wrong complementary gaps. Release from disable and from undervoltage is checked for refresh width and for the hold-off of the high-side gate. A refresh that was too short, or a high side that turned on during the refresh, would be reported. Narrow pulses below the filter width and turn-on requests withdrawn inside the dead time must leave no trace on the gates. A design that passed glitches, or that let a stale count complete, would emit a spurious gate pulse.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Per-leg strobes from the control section to the gate datapath.
  typedef struct packed {
    logic refresh;   // bootstrap refresh pulse active
    logic highReq;   // high-side turn-on requested
    logic lowReq;    // low-side turn-on requested
  } legStrobe_t;
endpackage

// File: rtl/hbg_in_cond.sv
module hbg_in_cond #(
  parameter int WIDTH = 2,
  parameter int MIN_PULSE = 3,
  parameter bit USE_FILTER = 1'b1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] cleanOut
);
  localparam int CW = $clog2(MIN_PULSE) + 1;

  logic [WIDTH-1:0] metaQ;
  logic [WIDTH-1:0] stableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ   <= RESET_VAL;
      stableQ <= RESET_VAL;
    end else begin
      metaQ   <= rawIn;
      stableQ <= metaQ;
    end
  end

  if (USE_FILTER) begin : g_filter
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [CW-1:0] runQ;
      logic          heldQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runQ  <= '0;
          heldQ <= RESET_VAL[b];
        end else if (stableQ[b] == heldQ) begin
          runQ <= '0;
        end else if (runQ == CW'(MIN_PULSE - 1)) begin
          heldQ <= stableQ[b];
          runQ  <= '0;
        end else begin
          runQ <= runQ + 1'b1;
        end
      end
      assign cleanOut[b] = heldQ;
    end
  end else begin : g_direct
    assign cleanOut = stableQ;
  end
endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int NUM_LEGS = 2,
  parameter int MIN_PULSE = 3,
  parameter int REFRESH_LEN = 20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      disableIn,
  input  logic                      supplyUv,
  input  logic [NUM_LEGS-1:0]       bootUv,
  input  logic [NUM_LEGS-1:0]       lowIn,
  input  logic [NUM_LEGS-1:0]       highIn,
  output legStrobe_t [NUM_LEGS-1:0] strobes
);
  localparam int RW = $clog2(REFRESH_LEN + 1);
  localparam int SAFE_W = NUM_LEGS + 2;

  logic [2*NUM_LEGS-1:0] legClean;
  logic [SAFE_W-1:0]     safeClean;
  logic [NUM_LEGS-1:0]   lowF, highF, bootF;
  logic                  disS, uvS;

  // Leg commands: synchronised and pulse-width filtered.
  hbg_in_cond #(
    .WIDTH(2*NUM_LEGS), .MIN_PULSE(MIN_PULSE), .USE_FILTER(1'b1),
    .RESET_VAL('0)
  ) u_legCond (
    .clk(clk), .rstN(rstN), .rawIn({highIn, lowIn}), .cleanOut(legClean)
  );

  // Protection inputs: synchronised only, reset to the safe (active) state.
  hbg_in_cond #(
    .WIDTH(SAFE_W), .MIN_PULSE(1), .USE_FILTER(1'b0),
    .RESET_VAL({SAFE_W{1'b1}})
  ) u_safeCond (
    .clk(clk), .rstN(rstN), .rawIn({bootUv, supplyUv, disableIn}),
    .cleanOut(safeClean)
  );

  assign lowF  = legClean[NUM_LEGS-1:0];
  assign highF = legClean[2*NUM_LEGS-1:NUM_LEGS];
  assign disS  = safeClean[0];
  assign uvS   = safeClean[1];
  assign bootF = safeClean[SAFE_W-1:2];

  logic          enable, enableQ, refActive, runOk;
  logic [RW-1:0] refCnt;

  assign enable = ~disS & ~uvS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      refCnt  <= '0;
    end else begin
      enableQ <= enable;
      if (!enable)
        refCnt <= '0;
      else if (!enableQ)
        refCnt <= RW'(REFRESH_LEN);
      else if (refCnt != '0)
        refCnt <= refCnt - 1'b1;
    end
  end

  assign refActive = (refCnt != '0);
  assign runOk     = enable & enableQ & ~refActive;

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    assign strobes[l].lowReq  = runOk & lowF[l];
    assign strobes[l].highReq = runOk & highF[l] & ~lowF[l] & ~bootF[l];
    assign strobes[l].refresh = refActive;
  end

  // R9: leaving disable/undervoltage starts the refresh window.
  p_refresh_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !enableQ) |=> refActive);
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int NUM_LEGS = 2,
  parameter int DEAD_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  legStrobe_t [NUM_LEGS-1:0] strobes,
  input  logic [DEAD_W-1:0]         deadCycles,
  output logic [NUM_LEGS-1:0]       lowGate,
  output logic [NUM_LEGS-1:0]       highGate
);
  localparam int NOUT = 2 * NUM_LEGS;

  logic [NOUT-1:0] onVec;   // even index: low side, odd index: high side

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam int LEG = k / 2;
    logic              req;
    logic              onQ, pendQ;
    logic [DEAD_W-1:0] cntQ;

    if (k % 2 == 0) begin : g_low
      assign req = strobes[LEG].lowReq;
    end else begin : g_high
      assign req = strobes[LEG].highReq;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onQ   <= 1'b0;
        pendQ <= 1'b0;
        cntQ  <= '0;
      end else if (!req) begin
        onQ   <= 1'b0;
        pendQ <= 1'b0;
        cntQ  <= '0;
      end else if (!onQ && !pendQ) begin
        if (deadCycles == '0) begin
          onQ <= 1'b1;
        end else begin
          pendQ <= 1'b1;
          cntQ  <= deadCycles - 1'b1;
        end
      end else if (pendQ) begin
        if (cntQ == '0) begin
          onQ   <= 1'b1;
          pendQ <= 1'b0;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end

    assign onVec[k] = onQ;
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    assign lowGate[l]  = onVec[2*l] | strobes[l].refresh;
    assign highGate[l] = onVec[2*l+1];

    // R3: the two switches of a leg never conduct together.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(lowGate[l] && highGate[l]));

    // R7: with a nonzero dead time, each side rises only after the other was off.
    p_dead_gap_high_r7: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(highGate[l]) && $past(deadCycles) != '0) |-> $past(!lowGate[l]));
    p_dead_gap_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(onVec[2*l]) && $past(deadCycles) != '0) |-> $past(!highGate[l]));
  end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int NUM_LEGS = 2,
  parameter int DEAD_W = 8,
  parameter int MIN_PULSE = 3,
  parameter int REFRESH_LEN = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                disableIn,
  input  logic                supplyUv,
  input  logic [NUM_LEGS-1:0] bootUv,
  input  logic [NUM_LEGS-1:0] lowIn,
  input  logic [NUM_LEGS-1:0] highIn,
  input  logic [DEAD_W-1:0]   deadCycles,
  output logic [NUM_LEGS-1:0] lowGate,
  output logic [NUM_LEGS-1:0] highGate
);
  legStrobe_t [NUM_LEGS-1:0] strobes;

  hbg_ctrl #(
    .NUM_LEGS(NUM_LEGS), .MIN_PULSE(MIN_PULSE), .REFRESH_LEN(REFRESH_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .disableIn(disableIn), .supplyUv(supplyUv),
    .bootUv(bootUv), .lowIn(lowIn), .highIn(highIn), .strobes(strobes)
  );

  hbg_datapath #(
    .NUM_LEGS(NUM_LEGS), .DEAD_W(DEAD_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .deadCycles(deadCycles),
    .lowGate(lowGate), .highGate(highGate)
  );

  // R1: disable held for three samples leaves every gate off.
  p_dis_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (disableIn && $past(disableIn) && $past(disableIn, 2) && $past(disableIn, 3))
    |-> (lowGate == '0 && highGate == '0));

  // R2: supply undervoltage held for three samples leaves every gate off.
  p_uv_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (supplyUv && $past(supplyUv) && $past(supplyUv, 2) && $past(supplyUv, 3))
    |-> (lowGate == '0 && highGate == '0));

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_chk
    // R4: bootstrap undervoltage held for three samples keeps the high side off.
    p_boot_block_r4: assert property (@(posedge clk) disable iff (!rstN)
      (bootUv[l] && $past(bootUv[l]) && $past(bootUv[l], 2) && $past(bootUv[l], 3))
      |-> !highGate[l]);
  end
endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
  localparam int NL = 2;
  localparam int DW = 8;
  localparam int MP = 3;
  localparam int RL = 20;
  localparam int OFF_LAT = MP + 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          disableIn = 1'b1;
  logic          supplyUv = 1'b0;
  logic [NL-1:0] bootUv = '0;
  logic [NL-1:0] lowIn = '0;
  logic [NL-1:0] highIn = '0;
  logic [DW-1:0] deadCycles = 8'd4;
  logic [NL-1:0] lowGate, highGate;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hbridge_gate_ctrl #(
    .NUM_LEGS(NL), .DEAD_W(DW), .MIN_PULSE(MP), .REFRESH_LEN(RL)
  ) u_hbridge_gate_ctrl (
    .clk(clk), .rstN(rstN), .disableIn(disableIn), .supplyUv(supplyUv),
    .bootUv(bootUv), .lowIn(lowIn), .highIn(highIn), .deadCycles(deadCycles),
    .lowGate(lowGate), .highGate(highGate)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic gate(input int leg, input bit high);
    return high ? highGate[leg] : lowGate[leg];
  endfunction

  // Counts negedges until the gate reaches the value; returns 0 if never.
  task automatic waitGate(input int leg, input bit high, input logic val, output int n);
    n = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (gate(leg, high) == val) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic testReset();
    lowIn = 2'b11; highIn = 2'b11;
    step(5);
    check("R11 gates in reset", {lowGate, highGate}, 0);
    rstN = 1'b1;
    step(15);
    check("R11 gates after reset while disabled", {lowGate, highGate}, 0);
    check("R1 disabled with commands high", {lowGate, highGate}, 0);
    lowIn = 2'b00; highIn = 2'b01;
    step(10);
  endtask

  // Release and measure refresh pulse and high-side hold-off on leg A.
  task automatic measureRelease(input string tag);
    int lowStart, lowEnd, highStart, highInRefresh, legBHigh;
    lowStart = 0; lowEnd = 0; highStart = 0; highInRefresh = 0; legBHigh = 0;
    for (int i = 1; i <= 70; i++) begin
      @(negedge clk);
      if (lowGate == 2'b11 && lowStart == 0) lowStart = i;
      if (lowStart != 0 && lowEnd == 0 && lowGate == 2'b00) lowEnd = i;
      if (highGate[0] && highStart == 0) highStart = i;
      if (highGate[0] && lowEnd == 0) highInRefresh++;
      if (highGate[1]) legBHigh++;
    end
    check({tag, " R9 refresh start edge"}, lowStart, 3);
    check({tag, " R9 refresh width"}, lowEnd - lowStart, RL);
    check({tag, " R9 high held during refresh"}, highInRefresh, 0);
    check({tag, " R9 high turn-on after refresh"}, highStart - lowEnd, int'(deadCycles) + 1);
    check({tag, " R8 idle leg B high stays off"}, legBHigh, 0);
  endtask

  task automatic testRefresh();
    deadCycles = 8'd4;
    disableIn = 1'b0;
    measureRelease("release-disable");
  endtask

  task automatic testHighSide();
    check("R4 high on with boot ok", highGate[0], 1);
    bootUv[0] = 1'b1;
    step(3);
    check("R4 boot flag forces high off", highGate[0], 0);
    step(15);
    check("R4 boot flag keeps high off", {lowGate[0], highGate[0]}, 0);
    bootUv[0] = 1'b0;
    step(20);
    check("R4 high back on after boot flag clears", highGate[0], 1);
  endtask

  task automatic testPriority();
    lowIn[0] = 1'b1;
    step(20);
    check("R3 low wins over high", {lowGate[0], highGate[0]}, 2);
  endtask

  task automatic testBothLow();
    lowIn[0] = 1'b0; highIn[0] = 1'b0;
    step(20);
    check("R5 both commands low", {lowGate[0], highGate[0]}, 0);
  endtask

  task automatic testLatency();
    int n;
    deadCycles = 8'd3;
    step(2);
    lowIn[0] = 1'b1;
    waitGate(0, 1'b0, 1'b1, n);
    check("R6 turn-on latency D=3", n, OFF_LAT + 3);
    step(5);
    lowIn[0] = 1'b0;
    waitGate(0, 1'b0, 1'b0, n);
    check("R6 turn-off latency", n, OFF_LAT);
    deadCycles = 8'd0;
    step(5);
    lowIn[0] = 1'b1;
    waitGate(0, 1'b0, 1'b1, n);
    check("R6 turn-on latency D=0", n, OFF_LAT);
    lowIn[0] = 1'b0;
    step(20);
  endtask

  task automatic measureSwap(input int leg, input bit offHigh, output int offAt, output int onAt);
    offAt = 0; onAt = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (offAt == 0 && gate(leg, offHigh) == 1'b0) offAt = i;
      if (onAt == 0 && gate(leg, !offHigh) == 1'b1) onAt = i;
    end
  endtask

  task automatic testComplementary();
    int offAt, onAt;
    int aChanges;
    logic aPrev;
    deadCycles = 8'd5;
    highIn[0] = 1'b1;        // leg A steady high side
    highIn[1] = 1'b1; lowIn[1] = 1'b1;
    step(30);
    check("R7 leg B starts low-on", {lowGate[1], highGate[1]}, 2);
    aPrev = highGate[0];
    check("R8 leg A high steady on", aPrev, 1);
    lowIn[1] = 1'b0;
    measureSwap(1, 1'b0, offAt, onAt);
    check("R7 low-off to high-on gap", onAt - offAt, 5);
    check("R6 low-off latency in complementary mode", offAt, OFF_LAT);
    aChanges = 0;
    lowIn[1] = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (highGate[0] != aPrev) aChanges++;
      if (offAt == 0) offAt = 0;
    end
    check("R7 leg B back to low-on", {lowGate[1], highGate[1]}, 2);
    lowIn[1] = 1'b0;
    step(40);
    lowIn[1] = 1'b1;
    measureSwap(1, 1'b1, offAt, onAt);
    check("R7 high-off to low-on gap", onAt - offAt, 5);
    bootUv[1] = 1'b1;
    step(20);
    check("R8 leg A unchanged by leg B activity", aChanges + (highGate[0] ? 0 : 1), 0);
    bootUv[1] = 1'b0;
    highIn = 2'b00; lowIn = 2'b00;
    step(30);
  endtask

  task automatic pulseCount(input int width, output int cnt);
    cnt = 0;
    lowIn[1] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (lowGate[1]) cnt++;
      if (i == width - 1) lowIn[1] = 1'b0;
    end
    step(10);
  endtask

  task automatic testPulses();
    int cnt;
    deadCycles = 8'd2;
    step(2);
    pulseCount(MP - 1, cnt);
    check("R10 short pulse ignored", cnt, 0);
    pulseCount(MP + 1, cnt);
    check("R10 pulse width minus dead time", cnt, MP + 1 - 2);
    deadCycles = 8'd5;
    step(2);
    pulseCount(MP, cnt);
    check("R12 request withdrawn inside dead time", cnt, 0);
    pulseCount(8, cnt);
    check("R12 fresh count after cancel", cnt, 3);
  endtask

  task automatic testDisableOverride();
    int n, stray;
    lowIn = 2'b01; highIn = 2'b10;
    deadCycles = 8'd1;
    step(30);
    check("R1 pre-disable gates on", {lowGate, highGate}, 6);
    disableIn = 1'b1;
    waitGate(0, 1'b0, 1'b0, n);
    check("R1 disable off edge", n, 3);
    check("R1 all gates off", {lowGate, highGate}, 0);
    stray = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      lowIn = 2'(i);
      highIn = 2'(i >> 1);
      if ({lowGate, highGate} != 0) stray++;
    end
    check("R1 commands ignored while disabled", stray, 0);
    lowIn = 2'b00; highIn = 2'b01;
    step(10);
    disableIn = 1'b0;
    step(60);
  endtask

  task automatic testUndervoltage();
    int n;
    deadCycles = 8'd2;
    lowIn = 2'b10; highIn = 2'b01;
    step(30);
    check("R2 pre-uv gates on", {lowGate, highGate}, 9);
    supplyUv = 1'b1;
    n = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (n == 0 && {lowGate, highGate} == 0) n = i;
    end
    check("R2 uv off edge", n, 3);
    step(20);
    check("R2 held off in uv", {lowGate, highGate}, 0);
    lowIn = 2'b00;
    step(10);
    supplyUv = 1'b0;
    measureRelease("release-uv");
  endtask

  initial begin
    step(1);
    testReset();
    testRefresh();
    testHighSide();
    testPriority();
    testBothLow();
    testLatency();
    testComplementary();
    testPulses();
    testDisableOverride();
    testUndervoltage();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule